// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides, for one memory access that goes through a two-level translation, whether the access is allowed. It looks at the flag bits of one directory entry and of one leaf entry, the kind of access (user or supervisor, read, write or instruction fetch) and four processor control bits. From these it produces a fault flag and a 6-bit fault error code. When the access is allowed, it also produces strobes naming the accessed and dirty bits that the page walker must set.

The decision follows a fixed priority. Entry validity is checked first, the directory before the leaf. Merged permissions come next. Protection keys are evaluated last, and they only add to the fault and to the error code. A directory entry marked as a large page is itself the leaf, so the leaf inputs are ignored. By default the block is purely combinational: its outputs belong to the cycle in which the input-valid strobe is high. Setting a parameter adds one register stage at the outputs.

Top module: `page_access_checker`

## Requirements
- R1: The error code has the layout bit0 present, bit1 write, bit2 user, bit3 reserved-bit violation, bit4 instruction fetch, bit5 protection key. Bit0 starts at 1, and bits 1, 2 and 4 are copies of accWrite, accUser and accFetch.
- R2: A directory entry that is not present faults and clears bit0. So does a leaf entry that is not present on a walk that is not a large page. Bit3 stays 0 in both cases.
- R3: A present entry faults and sets bit3 when its reserved flag is set. It also faults and sets bit3 when its no-execute flag is set while ctlNxEnable is 0. Bit0 stays 1.
- R4: The effective rights are merged across levels. Writable needs both writable flags and upperReadOnly at 0. User needs both user flags. Executable needs both no-execute flags at 0. With dirLarge set, only the directory entry counts and every leaf input is ignored.
- R5: A write to a page that is not writable faults. The one exception is a supervisor write (accUser=0) while ctlWriteProt is 0, which succeeds.
- R6: A user access to a page whose effective user right is 0 always faults.
- R7: A fetch from a non-executable page faults. A supervisor fetch from a user page faults when ctlSupExecProt is 1.
- R8: Bit4 of the error code is 0 whenever ctlNxEnable and ctlSupExecProt are both 0.
- R9: Protection keys apply only when all of the following hold: the page is a user page, the access is not a fetch, keyMatch is 1 and ctlKeyEnable is 1. In that case keyAccessDis faults any access. keyWriteDis faults a write, except a supervisor write while ctlWriteProt is 0. Either key fault sets bit5.
- R10: When the access does not fault, setLeafAccessed is 1, and setLeafDirty is 1 if the access is a write. When it faults, both are 0. On a large page the leaf strobes refer to the directory entry.
- R11: setDirAccessed is 1 when the directory entry is valid and is not a large page, even if the leaf then faults. It is 0 for a large page and for a directory fault.
- R12: With the default parameter the outputs belong to the same cycle as inValid, and outValid equals inValid. While inValid is 0, fault, errCode and all strobes are 0.
- R13: A directory fault takes priority over every later check. Leaf, permission and key inputs then have no effect on the error code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the optional output stage |
| rstN | input | 1 | Active-low reset |
| inValid | input | 1 | Access request strobe |
| dirPresent | input | 1 | Directory entry present |
| dirWritable | input | 1 | Directory entry writable |
| dirUser | input | 1 | Directory entry user-accessible |
| dirNoExec | input | 1 | Directory entry no-execute |
| dirRsvd | input | 1 | Directory entry has a reserved bit set |
| dirLarge | input | 1 | Directory entry maps a large page (it is the leaf) |
| leafPresent | input | 1 | Leaf entry present |
| leafWritable | input | 1 | Leaf entry writable |
| leafUser | input | 1 | Leaf entry user-accessible |
| leafNoExec | input | 1 | Leaf entry no-execute |
| leafRsvd | input | 1 | Leaf entry has a reserved bit set |
| upperReadOnly | input | 1 | An upper level forces read-only |
| keyMatch | input | 1 | The page carries the protection key under test |
| keyAccessDis | input | 1 | That key disables all data access |
| keyWriteDis | input | 1 | That key disables writes |
| accUser | input | 1 | Access made at user privilege |
| accWrite | input | 1 | Access is a write |
| accFetch | input | 1 | Access is an instruction fetch |
| ctlWriteProt | input | 1 | Supervisor writes honour read-only pages |
| ctlNxEnable | input | 1 | No-execute flags are enabled |
| ctlSupExecProt | input | 1 | Supervisor fetches from user pages fault |
| ctlKeyEnable | input | 1 | Protection keys are enabled |
| outValid | output | 1 | Result valid |
| fault | output | 1 | Access faults |
| errCode | output | 6 | Fault error code |
| setDirAccessed | output | 1 | Set accessed bit of the directory entry |
| setLeafAccessed | output | 1 | Set accessed bit of the leaf entry |
| setLeafDirty | output | 1 | Set dirty bit of the leaf entry |

## Verification
On every cycle with a request, the assertions check the following. A missing directory entry or a user access to a supervisor page always faults. A large page never marks the directory as passed through. Key faults occur only inside their scope. Dirty is marked only on a successful write. The reserved bit never appears without the present bit. The fetch bit is masked when both execute controls are off. The exact error code values, the supervisor write-protect override and the way leaf rights are ignored under a large page can only be shown by the bench scenarios, which compare every output against values worked out by hand.

// File: rtl/pac_pkg.sv
package pac_pkg;
  localparam int ERR_W      = 6;
  localparam int ERR_PRESENT = 0;
  localparam int ERR_WRITE   = 1;
  localparam int ERR_USER    = 2;
  localparam int ERR_RSVD    = 3;
  localparam int ERR_FETCH   = 4;
  localparam int ERR_KEY     = 5;

  typedef struct packed {
    logic fault;
    logic notPresent;
    logic rsvd;
    logic keyHit;
    logic dirPass;
    logic leafAcc;
    logic leafDirty;
  } pacDecision_t;
endpackage

// File: rtl/pac_entry_check.sv
module pac_entry_check (
  input  logic present,
  input  logic rsvd,
  input  logic noExec,
  input  logic nxEnable,
  output logic valid
);
  // a no-execute flag without no-execute support is treated as reserved
  always_comb valid = present && !rsvd && !(noExec && !nxEnable);
endmodule

// File: rtl/pac_control.sv
module pac_control
  import pac_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         dirValid,
  input  logic         dirPresent,
  input  logic         dirUser,
  input  logic         dirLarge,
  input  logic         leafValid,
  input  logic         leafPresent,
  input  logic         effWritable,
  input  logic         effUser,
  input  logic         effExec,
  input  logic         keyMatch,
  input  logic         keyAccessDis,
  input  logic         keyWriteDis,
  input  logic         accUser,
  input  logic         accWrite,
  input  logic         accFetch,
  input  logic         ctlWriteProt,
  input  logic         ctlSupExecProt,
  input  logic         ctlKeyEnable,
  output pacDecision_t dec
);
  logic dirFault, leafFault, walkFault;
  logic kernWrite, permFault, keyGate, keyFault;

  always_comb begin
    dirFault  = !dirValid;
    leafFault = dirValid && !dirLarge && !leafValid;
    walkFault = dirFault || leafFault;
    // supervisor write allowed on read-only pages when write-protect is off
    kernWrite = !ctlWriteProt && !accUser;
    permFault = (accUser && !effUser)
             || (accWrite && !effWritable && !kernWrite)
             || (accFetch && !effExec)
             || (accFetch && !accUser && effUser && ctlSupExecProt);
    keyGate   = effUser && !accFetch && keyMatch && ctlKeyEnable;
    keyFault  = keyGate && (keyAccessDis || (accWrite && keyWriteDis && !kernWrite));

    dec            = '0;
    dec.notPresent = dirFault ? !dirPresent : (leafFault && !leafPresent);
    dec.rsvd       = dirFault ? dirPresent  : (leafFault && leafPresent);
    dec.keyHit     = !walkFault && keyFault;
    dec.fault      = walkFault || permFault || keyFault;
    dec.dirPass    = dirValid && !dirLarge;
    dec.leafAcc    = !dec.fault;
    dec.leafDirty  = !dec.fault && accWrite;
  end

  p_nonpresent_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !dirPresent |-> dec.fault && !dec.dirPass);

  p_user_super_r6: assert property (@(posedge clk) disable iff (!rstN)
    inValid && accUser && dirValid && !dirUser |-> dec.fault);

  p_key_scope_r9: assert property (@(posedge clk) disable iff (!rstN)
    inValid && dec.keyHit |-> ctlKeyEnable && !accFetch && keyMatch && effUser);

  p_dirty_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    inValid && dec.leafDirty |-> accWrite && dec.leafAcc);

  p_large_no_dir_acc_r11: assert property (@(posedge clk) disable iff (!rstN)
    inValid && dirLarge |-> !dec.dirPass);
endmodule

// File: rtl/pac_datapath.sv
module pac_datapath
  import pac_pkg::*;
#(
  parameter bit REG_OUT = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             dirPresent,
  input  logic             dirWritable,
  input  logic             dirUser,
  input  logic             dirNoExec,
  input  logic             dirRsvd,
  input  logic             dirLarge,
  input  logic             leafPresent,
  input  logic             leafWritable,
  input  logic             leafUser,
  input  logic             leafNoExec,
  input  logic             leafRsvd,
  input  logic             upperReadOnly,
  input  logic             accUser,
  input  logic             accWrite,
  input  logic             accFetch,
  input  logic             ctlNxEnable,
  input  logic             ctlSupExecProt,
  input  pacDecision_t     dec,
  output logic             dirValid,
  output logic             leafValid,
  output logic             effWritable,
  output logic             effUser,
  output logic             effExec,
  output logic             outValid,
  output logic             fault,
  output logic [ERR_W-1:0] errCode,
  output logic             setDirAccessed,
  output logic             setLeafAccessed,
  output logic             setLeafDirty
);
  localparam int OUT_W = ERR_W + 5;

  pac_entry_check i_dirCheck (
    .present(dirPresent), .rsvd(dirRsvd), .noExec(dirNoExec),
    .nxEnable(ctlNxEnable), .valid(dirValid)
  );
  pac_entry_check i_leafCheck (
    .present(leafPresent), .rsvd(leafRsvd), .noExec(leafNoExec),
    .nxEnable(ctlNxEnable), .valid(leafValid)
  );

  // rights merge: a large page makes the directory the leaf
  always_comb begin
    effWritable = dirWritable && !upperReadOnly && (dirLarge || leafWritable);
    effUser     = dirUser && (dirLarge || leafUser);
    effExec     = !dirNoExec && (dirLarge || !leafNoExec);
  end

  logic [ERR_W-1:0] errNow;
  logic [OUT_W-1:0] outNow;

  always_comb begin
    errNow              = '0;
    errNow[ERR_PRESENT] = !dec.notPresent;
    errNow[ERR_WRITE]   = accWrite;
    errNow[ERR_USER]    = accUser;
    errNow[ERR_RSVD]    = dec.rsvd;
    errNow[ERR_FETCH]   = accFetch && (ctlNxEnable || ctlSupExecProt);
    errNow[ERR_KEY]     = dec.keyHit;
    outNow = inValid ? {1'b1, dec.fault, errNow, dec.dirPass, dec.leafAcc, dec.leafDirty}
                     : '0;
  end

  logic [OUT_W-1:0] outSel;

  generate
    if (REG_OUT) begin : g_reg
      logic [OUT_W-1:0] outQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) outQ <= '0;
        else       outQ <= outNow;
      end
      assign outSel = outQ;
    end else begin : g_comb
      assign outSel = outNow;
    end
  endgenerate

  assign {outValid, fault, errCode, setDirAccessed, setLeafAccessed, setLeafDirty} = outSel;

  p_rsvd_present_r3: assert property (@(posedge clk) disable iff (!rstN)
    inValid && dec.rsvd |-> errNow[ERR_PRESENT] && dec.fault);

  p_fetch_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !ctlNxEnable && !ctlSupExecProt |-> !errNow[ERR_FETCH]);

  p_dir_first_r13: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !dirValid |-> !dec.keyHit && !dec.leafAcc);
endmodule

// File: rtl/page_access_checker.sv
module page_access_checker
  import pac_pkg::*;
#(
  parameter bit REG_OUT = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             dirPresent,
  input  logic             dirWritable,
  input  logic             dirUser,
  input  logic             dirNoExec,
  input  logic             dirRsvd,
  input  logic             dirLarge,
  input  logic             leafPresent,
  input  logic             leafWritable,
  input  logic             leafUser,
  input  logic             leafNoExec,
  input  logic             leafRsvd,
  input  logic             upperReadOnly,
  input  logic             keyMatch,
  input  logic             keyAccessDis,
  input  logic             keyWriteDis,
  input  logic             accUser,
  input  logic             accWrite,
  input  logic             accFetch,
  input  logic             ctlWriteProt,
  input  logic             ctlNxEnable,
  input  logic             ctlSupExecProt,
  input  logic             ctlKeyEnable,
  output logic             outValid,
  output logic             fault,
  output logic [ERR_W-1:0] errCode,
  output logic             setDirAccessed,
  output logic             setLeafAccessed,
  output logic             setLeafDirty
);
  pacDecision_t dec;
  logic dirValid, leafValid, effWritable, effUser, effExec;

  pac_control i_control (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .dirValid(dirValid), .dirPresent(dirPresent), .dirUser(dirUser), .dirLarge(dirLarge),
    .leafValid(leafValid), .leafPresent(leafPresent),
    .effWritable(effWritable), .effUser(effUser), .effExec(effExec),
    .keyMatch(keyMatch), .keyAccessDis(keyAccessDis), .keyWriteDis(keyWriteDis),
    .accUser(accUser), .accWrite(accWrite), .accFetch(accFetch),
    .ctlWriteProt(ctlWriteProt), .ctlSupExecProt(ctlSupExecProt),
    .ctlKeyEnable(ctlKeyEnable), .dec(dec)
  );

  pac_datapath #(.REG_OUT(REG_OUT)) i_datapath (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .dirPresent(dirPresent), .dirWritable(dirWritable), .dirUser(dirUser),
    .dirNoExec(dirNoExec), .dirRsvd(dirRsvd), .dirLarge(dirLarge),
    .leafPresent(leafPresent), .leafWritable(leafWritable), .leafUser(leafUser),
    .leafNoExec(leafNoExec), .leafRsvd(leafRsvd), .upperReadOnly(upperReadOnly),
    .accUser(accUser), .accWrite(accWrite), .accFetch(accFetch),
    .ctlNxEnable(ctlNxEnable), .ctlSupExecProt(ctlSupExecProt), .dec(dec),
    .dirValid(dirValid), .leafValid(leafValid),
    .effWritable(effWritable), .effUser(effUser), .effExec(effExec),
    .outValid(outValid), .fault(fault), .errCode(errCode),
    .setDirAccessed(setDirAccessed), .setLeafAccessed(setLeafAccessed),
    .setLeafDirty(setLeafDirty)
  );
endmodule

// File: tb/test_page_access_checker.sv
module test_page_access_checker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic dirPresent, dirWritable, dirUser, dirNoExec, dirRsvd, dirLarge;
  logic leafPresent, leafWritable, leafUser, leafNoExec, leafRsvd, upperReadOnly;
  logic keyMatch, keyAccessDis, keyWriteDis, accUser, accWrite, accFetch;
  logic ctlWriteProt, ctlNxEnable, ctlSupExecProt, ctlKeyEnable;
  logic outValid, fault, setDirAccessed, setLeafAccessed, setLeafDirty;
  logic [5:0] errCode;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  page_access_checker i_page_access_checker (.*);

  // stim: dir{P W U NX RSV LARGE} leaf{P W U NX RSV} ro key{MATCH AD WD} acc{U W F} ctl{WP NXE SEP KEYEN}
  // result: fault, err{KEY FETCH RSVD USER WRITE PRESENT}, dirAcc, leafAcc, leafDirty
  typedef struct packed {
    logic [21:0] stim;
    logic        expFault;
    logic [5:0]  expErr;
    logic [2:0]  expStb;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    {22'b111000_11100_0_000_000_1100, 1'b0, 6'b000001, 3'b110}, // R1 plain read
    {22'b111000_10100_0_000_010_1100, 1'b1, 6'b000011, 3'b100}, // R5 sup write RO, wp on
    {22'b111000_10100_0_000_010_0100, 1'b0, 6'b000011, 3'b111}, // R5 sup write RO, wp off
    {22'b111000_10100_0_000_110_0100, 1'b1, 6'b000111, 3'b100}, // R5 user write RO
    {22'b111000_11000_0_000_100_1100, 1'b1, 6'b000101, 3'b100}, // R6 user on supervisor leaf
    {22'b111000_01100_0_000_000_1100, 1'b1, 6'b000000, 3'b100}, // R2 leaf not present
    {22'b011000_11100_0_000_010_1100, 1'b1, 6'b000010, 3'b000}, // R13 dir not present
    {22'b111000_11101_0_000_000_1100, 1'b1, 6'b001001, 3'b100}, // R3 leaf reserved
    {22'b111000_11110_0_000_000_1000, 1'b1, 6'b001001, 3'b100}, // R3 leaf NX without NXE
    {22'b111000_11110_0_000_001_1100, 1'b1, 6'b010001, 3'b100}, // R7 fetch NX page
    {22'b111000_11100_0_000_001_1110, 1'b1, 6'b010001, 3'b100}, // R7 sup fetch user page
    {22'b111000_11100_0_000_001_1000, 1'b0, 6'b000001, 3'b110}, // R8 fetch bit masked
    {22'b111000_11100_0_110_100_1101, 1'b1, 6'b100101, 3'b100}, // R9 key access-disable
    {22'b111000_11100_0_101_010_1101, 1'b1, 6'b100011, 3'b100}, // R9 key write-disable wp on
    {22'b111000_11100_0_101_010_0101, 1'b0, 6'b000011, 3'b111}, // R9 key write-disable sup wp off
    {22'b111000_11100_0_110_100_1100, 1'b0, 6'b000101, 3'b110}, // R9 key ignored, enable off
    {22'b111000_11100_0_110_001_1101, 1'b0, 6'b010001, 3'b110}, // R9 key ignored on fetch
    {22'b111001_00000_0_000_010_1100, 1'b0, 6'b000011, 3'b011}, // R4 large page, leaf ignored
    {22'b101001_11100_0_000_010_1100, 1'b1, 6'b000011, 3'b000}, // R11 large RO write
    {22'b111000_11100_1_000_010_1100, 1'b1, 6'b000011, 3'b100}, // R4 upper read-only
    {22'b111010_11100_0_000_000_1100, 1'b1, 6'b001001, 3'b000}, // R3 dir reserved
    {22'b111100_11100_0_000_000_1000, 1'b1, 6'b001001, 3'b000}, // R13 dir NX without NXE
    {22'b111000_11000_0_110_000_1101, 1'b0, 6'b000001, 3'b110}, // R9 key ignored, supervisor page
    {22'b111000_11100_0_010_100_1101, 1'b0, 6'b000101, 3'b110}  // R10 key no match, user read
  };

  string tags [NV] = '{"R1","R5","R5","R5","R6","R2","R13","R3","R3","R7","R7","R8",
                       "R9","R9","R9","R9","R9","R4","R11","R4","R3","R13","R9","R10"};

  task automatic applyStim(input logic [21:0] s, input logic v);
    @(negedge clk);
    {dirPresent, dirWritable, dirUser, dirNoExec, dirRsvd, dirLarge,
     leafPresent, leafWritable, leafUser, leafNoExec, leafRsvd, upperReadOnly,
     keyMatch, keyAccessDis, keyWriteDis, accUser, accWrite, accFetch,
     ctlWriteProt, ctlNxEnable, ctlSupExecProt, ctlKeyEnable} = s;
    inValid = v;
    #5;
  endtask

  task automatic checkOut(input string tag, input logic [10:0] expv);
    logic [10:0] act;
    act = {outValid, fault, errCode, setDirAccessed, setLeafAccessed, setLeafDirty};
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R12 reset and idle: all outputs zero
    applyStim(22'b111000_11100_0_000_000_1100, 1'b0);
    checkOut("R12 reset", 11'b0);
    repeat (2) @(posedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      applyStim(VECS[i].stim, 1'b1);
      checkOut(tags[i], {1'b1, VECS[i].expFault, VECS[i].expErr, VECS[i].expStb});
    end

    // R12 idle with a faulting pattern: everything quiet
    applyStim(22'b011000_01101_1_110_110_1101, 1'b0);
    checkOut("R12 idle", 11'b0);
    // R12 same-cycle result when the strobe returns
    applyStim(22'b011000_01101_1_110_110_1101, 1'b1);
    checkOut("R12 same cycle", {1'b1, 1'b1, 6'b000110, 3'b000});
    // R4 large page with a reserved, non-executable leaf: still ignored
    applyStim(22'b111001_01011_0_000_001_1100, 1'b1);
    checkOut("R4 large leaf ignored", {1'b1, 1'b0, 6'b010001, 3'b010});
    // R11 dir accessed kept although the leaf faults on reserved
    applyStim(22'b111000_11101_0_000_010_1100, 1'b1);
    checkOut("R11 dir pass on leaf fault", {1'b1, 1'b1, 6'b001011, 3'b100});
    // R10 user write success marks dirty
    applyStim(22'b111000_11100_0_000_110_1100, 1'b1);
    checkOut("R10 user write ok", {1'b1, 1'b0, 6'b000111, 3'b111});

    applyStim(22'b0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule